// File: doc/BRIEF.md
# Command-Keyed Watchdog Timer

This block is a watchdog timer that software controls through two 32-bit registers. The control register accepts only fixed 16-bit command words. These commands stop the timer, resume it, clear the interrupt, open and close a reload key, and reload the counter to its full value. Any other value written to the control register has no effect.

The timer is a 20-bit down-counter. It steps once on each cycle where the external time-base enable is high; in the target system that enable pulses at 90 kHz. Software sees the counter through the count register. This register reads and loads the upper 16 counter bits, and the lowest four bits stay hidden.

A count load is accepted only while the key is open. When a running counter reaches zero, the block latches an interrupt flag and raises a reset request for one clock. To force a restart quickly, software loads a count of 1 and resumes the timer.

Top module: `cmd_watchdog`

## Requirements
- R1: After reset the timer is stopped, the key is closed, the counter holds 0xFFFFF, and both irqFlag and resetReq are low.
- R2: The control register sits at byte offset 0x0 and the count register at offset 0x4. A read at offset 0x4 returns counter bits [19:4] in bits [15:0], with zeros above. A read at any other offset returns zero.
- R3: While the timer is running, the counter drops by exactly one in each clock where tickEn is high. While the timer is stopped, tickEn has no effect.
- R4: A write to offset 0x4 loads data bits [15:0] into counter bits [19:4] and clears counter bits [3:0]. The write is accepted only after the control value 0x0000AB00 (open key) and before 0x0000AB01 (close key). A write while the key is closed leaves the counter unchanged.
- R5: Control value 0x00003877 freezes the counter. Control value 0x00004A4B restarts counting from the frozen value.
- R6: Control value 0x0000DEAF sets the counter to 0xFFFFF whatever the key state. It does not change the running state.
- R7: When a running counter goes from 1 to 0 on a tick, irqFlag and resetReq both go high in the next cycle. resetReq stays high for that one clock only. The counter then stays at zero until it is loaded again.
- R8: Control value 0x00007482 clears irqFlag. If an expiry happens in the same cycle as this command, irqFlag is set.
- R9: These writes are ignored and change no state: a control write whose 32-bit value is not one of the listed codes (including a listed code with any of bits [31:16] set), and any write to an offset other than 0x0 or 0x4.
- R10: A count load or a full reload in the same cycle as a tick leaves the counter exactly at the loaded value.
- R11: Loading a count of 1 and then resuming causes an expiry on the 16th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time-base enable, one clock per tick |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset for writes and reads |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| irqFlag | output | 1 | Sticky expiry interrupt flag |
| resetReq | output | 1 | One-clock reset request at expiry |

## Verification
The assertions check on every cycle that the counter never rises without a load, that it holds while stopped and while at zero, that the hidden bits are zero after a count load, and that the full reload gives all ones. They also check that the reset request lasts one clock and always comes with the interrupt flag. Only the bench scenarios can show the command decoding and the key gating of count writes. The same holds for the exact tick count to expiry, for continuing from a frozen value, and for what wins when a command or load meets a tick or an expiry in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CMD_W = 16;

  localparam logic [CMD_W-1:0] CMD_STOP   = 16'h3877;
  localparam logic [CMD_W-1:0] CMD_RESUME = 16'h4A4B;
  localparam logic [CMD_W-1:0] CMD_CLRIRQ = 16'h7482;
  localparam logic [CMD_W-1:0] CMD_OPEN   = 16'hAB00;
  localparam logic [CMD_W-1:0] CMD_CLOSE  = 16'hAB01;
  localparam logic [CMD_W-1:0] CMD_MAX    = 16'hDEAF;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic loadMax;
    logic loadCnt;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFF = 0,
  parameter int CNT_OFF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hitZero,
  output wdtStrobe_t        strobe,
  output logic              irqFlag,
  output logic              resetReq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFF);

  logic runQ, unlockedQ, irqQ, reqQ;
  logic isCtrl, isCnt, cmdOk;
  logic [CMD_W-1:0] cmd;
  logic doStop, doResume, doClr, doOpen, doClose, doMax;

  always_comb begin
    isCtrl   = wrEn && (wrAddr == CTRL_A);
    isCnt    = wrEn && (wrAddr == CNT_A);
    cmd      = wrData[CMD_W-1:0];
    cmdOk    = isCtrl && (wrData[DATA_W-1:CMD_W] == '0);
    doStop   = cmdOk && (cmd == CMD_STOP);
    doResume = cmdOk && (cmd == CMD_RESUME);
    doClr    = cmdOk && (cmd == CMD_CLRIRQ);
    doOpen   = cmdOk && (cmd == CMD_OPEN);
    doClose  = cmdOk && (cmd == CMD_CLOSE);
    doMax    = cmdOk && (cmd == CMD_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      unlockedQ <= 1'b0;
      irqQ      <= 1'b0;
      reqQ      <= 1'b0;
    end else begin
      if (doStop)        runQ <= 1'b0;
      else if (doResume) runQ <= 1'b1;
      if (doOpen)        unlockedQ <= 1'b1;
      else if (doClose)  unlockedQ <= 1'b0;
      if (hitZero)       irqQ <= 1'b1;
      else if (doClr)    irqQ <= 1'b0;
      reqQ <= hitZero;
    end
  end

  always_comb begin
    strobe.run     = runQ;
    strobe.loadMax = doMax;
    strobe.loadCnt = isCnt && unlockedQ;
  end

  assign irqFlag  = irqQ;
  assign resetReq = reqQ;

  // R7: request lasts a single clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R7: a request is always accompanied by the flag
  a_r7_req_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> irqFlag);
  // R8: clear without a coincident expiry drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (doClr && !hitZero) |=> !irqFlag);
  // R9: at most one load kind per cycle
  a_r9_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadMax, strobe.loadCnt}));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int VIS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  wdtStrobe_t       strobe,
  input  logic [VIS_W-1:0] loadData,
  output logic [VIS_W-1:0] cntVis,
  output logic             hitZero
);
  localparam int HID_W = CNT_W - VIS_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadVal;
  logic anyLoad, step;

  generate
    if (HID_W > 0) begin : g_hidden
      assign loadVal = {loadData, {HID_W{1'b0}}};
    end else begin : g_flat
      assign loadVal = loadData;
    end
  endgenerate

  always_comb begin
    anyLoad = strobe.loadMax || strobe.loadCnt;
    step    = strobe.run && tickEn && (cntQ != '0) && !anyLoad;
    hitZero = step && (cntQ == ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '1;
    else if (strobe.loadMax) cntQ <= '1;
    else if (strobe.loadCnt) cntQ <= loadVal;
    else if (step)           cntQ <= cntQ - ONE;
  end

  assign cntVis = cntQ[CNT_W-1:HID_W];

  // R3: never rises without a load
  a_r3_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadMax || strobe.loadCnt) |=> cntQ <= $past(cntQ));
  // R3/R5: frozen while stopped
  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.loadMax && !strobe.loadCnt) |=> $stable(cntQ));
  // R7: holds at zero until reloaded
  a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && !strobe.loadMax && !strobe.loadCnt) |=> cntQ == '0);
  // R4: hidden bits cleared by a count load
  a_r4_low_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCnt && !strobe.loadMax) |=> cntQ[HID_W-1:0] == '0);
  // R6: full reload
  a_r6_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadMax |=> cntQ == '1);
endmodule

// File: rtl/cmd_watchdog.sv
module cmd_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int VIS_W    = 16,
  parameter int CTRL_OFF = 0,
  parameter int CNT_OFF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqFlag,
  output logic              resetReq
);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_OFF);

  wdtStrobe_t       strobe;
  logic             hitZero;
  logic [VIS_W-1:0] cntVis;

  wdt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF), .CNT_OFF(CNT_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr),
    .wrData(regWrData), .hitZero(hitZero), .strobe(strobe),
    .irqFlag(irqFlag), .resetReq(resetReq)
  );

  wdt_counter #(.CNT_W(CNT_W), .VIS_W(VIS_W)) u_cnt (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .loadData(regWrData[VIS_W-1:0]), .cntVis(cntVis), .hitZero(hitZero)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == CNT_A) regRdData[VIS_W-1:0] = cntVis;
  end
endmodule

// File: tb/tb_cmd_watchdog.sv
module tb_cmd_watchdog;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqFlag, resetReq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmd_watchdog dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqFlag(irqFlag), .resetReq(resetReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tickWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; tickEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic rdCnt(output logic [31:0] v);
    regAddr = 4'h4;
    #1;
    v = regRdData;
  endtask

  task automatic loadCount(input logic [15:0] v);
    wr(4'h0, 32'h3877);
    wr(4'h0, 32'hAB00);
    wr(4'h4, {16'h0, v});
    wr(4'h0, 32'hAB01);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdCnt(v);
    chk("R1 count", v, 32'h0000FFFF);
    chk("R1 irq", irqFlag, 0);
    chk("R1 req", resetReq, 0);
    regAddr = 4'h0; #1;
    chk("R2 ctrl read zero", regRdData, 0);
    tick(20);
    rdCnt(v);
    chk("R3 stopped ignores ticks", v, 32'h0000FFFF);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(4'h4, 32'h1234);
    rdCnt(v);
    chk("R4 closed key write ignored", v, 32'h0000FFFF);
    wr(4'h0, 32'hAB00);
    wr(4'h4, 32'h1234);
    rdCnt(v);
    chk("R4 open key write", v, 32'h00001234);
    wr(4'h0, 32'hAB01);
    wr(4'h4, 32'h0055);
    rdCnt(v);
    chk("R4 closed again", v, 32'h00001234);
  endtask

  task automatic t_hidden_and_stop();
    logic [31:0] v;
    loadCount(16'h0002);
    wr(4'h0, 32'h4A4B);
    tick(1);
    rdCnt(v);
    chk("R4 low bits cleared", v, 32'h00000001);
    wr(4'h0, 32'h3877);
    tick(20);
    rdCnt(v);
    chk("R5 frozen", v, 32'h00000001);
    wr(4'h0, 32'h4A4B);
    tick(15);
    rdCnt(v);
    chk("R5 resumed at 0x10", v, 32'h00000001);
    tick(1);
    rdCnt(v);
    chk("R3 one step per tick", v, 32'h00000000);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    loadCount(16'h0002);
    wr(4'h0, 32'h4A4B);
    tick(31);
    chk("R7 no early irq", irqFlag, 0);
    chk("R7 no early req", resetReq, 0);
    tick(1);
    chk("R7 irq at expiry", irqFlag, 1);
    chk("R7 req at expiry", resetReq, 1);
    @(negedge clk);
    chk("R7 req one clock", resetReq, 0);
    tick(5);
    rdCnt(v);
    chk("R7 holds zero", v, 0);
    chk("R7 no repeat req", resetReq, 0);
    wr(4'h0, 32'h7482);
    chk("R8 clear irq", irqFlag, 0);
  endtask

  task automatic t_max_and_junk();
    logic [31:0] v;
    wr(4'h0, 32'hDEAF);
    rdCnt(v);
    chk("R6 full reload closed key", v, 32'h0000FFFF);
    tick(16);
    rdCnt(v);
    chk("R6 still running", v, 32'h0000FFFE);
    wr(4'h0, 32'h1234);
    wr(4'h0, 32'h0001_3877);
    wr(4'h8, 32'h3877);
    tick(16);
    rdCnt(v);
    chk("R9 junk ignored, running", v, 32'h0000FFFD);
    wr(4'h0, 32'hFFFF_AB00);
    wr(4'h4, 32'h0100);
    rdCnt(v);
    chk("R9 wide open ignored", v, 32'h0000FFFD);
  endtask

  task automatic t_load_vs_tick();
    logic [31:0] v;
    wr(4'h0, 32'hAB00);
    tickWr(4'h4, 32'h0040);
    rdCnt(v);
    chk("R10 load beats tick", v, 32'h00000040);
    tick(1);
    rdCnt(v);
    chk("R10 then steps", v, 32'h0000003F);
    wr(4'h0, 32'hAB01);
    tickWr(4'h0, 32'hDEAF);
    rdCnt(v);
    chk("R10 max beats tick", v, 32'h0000FFFF);
    tick(1);
    rdCnt(v);
    chk("R10 max then steps", v, 32'h0000FFFF);
  endtask

  task automatic t_restart();
    loadCount(16'h0001);
    wr(4'h0, 32'h4A4B);
    tick(15);
    chk("R11 not yet", resetReq, 0);
    tick(1);
    chk("R11 expiry on 16th tick", resetReq, 1);
    wr(4'h0, 32'h7482);
    chk("R8 cleared", irqFlag, 0);
  endtask

  task automatic t_clear_race();
    loadCount(16'h0001);
    wr(4'h0, 32'h4A4B);
    tick(15);
    tickWr(4'h0, 32'h7482);
    chk("R8 expiry beats clear", irqFlag, 1);
    wr(4'h0, 32'h7482);
    chk("R8 later clear", irqFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_hidden_and_stop();
    t_expire();
    t_max_and_junk();
    t_load_vs_tick();
    t_restart();
    t_clear_race();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule